// File: doc/BRIEF.md
# Phase Compensation Sample Delay

This block lines up the voltage and current sample streams of a single phase. One of the two streams is held back by a programmable whole number of sample periods. The other stream goes straight through. This cancels a fixed phase error between the two measurement paths before any power is computed from them.

The delay is the weighted sum of three configuration fields. The fine field is worth one sample each, the middle field 32 samples each, and the coarse field 128 samples each. A channel-choice bit selects which stream is delayed. Each field is clamped to a limit that depends on that choice.

The delayed stream is kept in a circular buffer that moves forward only when a sample strobe arrives. An output valid pulse appears only once the buffer holds enough history since the last configuration change to serve the programmed delay.

Top module: `phase_align_delay`

## Requirements
- R1: With the channel-choice bit at 0, the current output for strobe n equals the current sample of strobe n-D, where D is the fine field value (0 to 31) when the middle and coarse fields are 0.
- R2: The effective delay is D = fine + 32*middle + 128*coarse, after saturation of each field.
- R3: With the channel-choice bit at 1, the voltage stream is delayed by D. In either setting, the stream that is not chosen appears at the output unchanged, one clock after its own strobe.
- R4: When the current stream is delayed, the middle field uses its full range 0 to 3. A coarse value of 3 is treated as 2, so the largest delay is 383 samples.
- R5: When the voltage stream is delayed, a middle value of 2 or 3 is treated as 1, and the coarse field is treated as 0, so the largest delay is 63 samples.
- R6: Reset clears both sample outputs to 0 and the valid output to 0. The reset configuration (all fields 0, choice bit 0) is zero delay, so the first strobe after reset already gives a valid output carrying that strobe's own samples.
- R7: The outputs change only on the clock edge that registers a strobe. The valid output is a one-cycle pulse that follows a strobe. In a cycle without a strobe, valid is low on the next cycle and both sample outputs hold.
- R8: After a change of the effective delay or of the channel choice, the first D strobes give no valid pulse and strobe D (counted from 0) gives one. The same holds after reset with a non-zero configuration.
- R9: Idle cycles between strobes do not advance the buffer, so the delay is counted in strobes and not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | Strobe marking a new sample pair |
| v_smp | input | SAMPLE_W | Voltage sample |
| i_smp | input | SAMPLE_W | Current sample |
| dly_fine | input | FINE_W | Fine delay field, one sample per unit |
| dly_mid | input | MID_W | Middle delay field, 32 samples per unit |
| dly_coarse | input | COARSE_W | Coarse delay field, 128 samples per unit |
| dly_on_volt | input | 1 | 0 delays current, 1 delays voltage |
| v_aligned | output | SAMPLE_W | Aligned voltage sample |
| i_aligned | output | SAMPLE_W | Aligned current sample |
| aligned_vld | output | 1 | Pulse marking a valid aligned pair |

## Verification
The table of configurations covers several kinds of setting:
- fine-only delays, which isolate the unit weight;
- middle and coarse mixes, which separate the 32 and 128 weights;
- out-of-range fields in both channel settings, which show whether saturation follows the chosen channel;
- strobes spaced by idle cycles, which tell a strobe-counted delay from a clock-counted one.

Sample values follow two different linear ramps per channel, so a wrong tap, a swapped channel and an off-by-one delay each give a distinct wrong value. The position of the first valid pulse after each change separates a correct refill count from a premature or late one.

// File: rtl/pad_pkg.sv
package pad_pkg;

   // Which stream is held back in the buffer.
   typedef enum logic {
      DLY_CURRENT = 1'b0,
      DLY_VOLTAGE = 1'b1
   } dly_chan_e;

   // Largest delay reachable in the wider (current) setting.
   function automatic int unsigned pad_max_delay(input int unsigned fine_w,
                                                 input int unsigned mid_weight,
                                                 input int unsigned mid_max,
                                                 input int unsigned coarse_weight,
                                                 input int unsigned coarse_max);
      return (2 ** fine_w - 1) + mid_weight * mid_max + coarse_weight * coarse_max;
   endfunction

endpackage

// File: rtl/pad_delay_calc.sv
module pad_delay_calc
   import pad_pkg::*;
#(
   parameter int unsigned FINE_W          = 5,
   parameter int unsigned MID_W           = 2,
   parameter int unsigned COARSE_W        = 2,
   parameter int unsigned MID_WEIGHT      = 32,
   parameter int unsigned COARSE_WEIGHT   = 128,
   parameter int unsigned CUR_MID_MAX     = 3,
   parameter int unsigned CUR_COARSE_MAX  = 2,
   parameter int unsigned VOLT_MID_MAX    = 1,
   parameter int unsigned VOLT_COARSE_MAX = 0,
   parameter int unsigned DLY_W           = 9
) (
   input  logic [FINE_W-1:0]   fine,
   input  logic [MID_W-1:0]    mid,
   input  logic [COARSE_W-1:0] coarse,
   input  dly_chan_e           chan,
   output logic [DLY_W-1:0]    delay
);

   localparam logic [MID_W-1:0]    CUR_MID_LIM     = MID_W'(CUR_MID_MAX);
   localparam logic [MID_W-1:0]    VOLT_MID_LIM    = MID_W'(VOLT_MID_MAX);
   localparam logic [COARSE_W-1:0] CUR_COARSE_LIM  = COARSE_W'(CUR_COARSE_MAX);
   localparam logic [COARSE_W-1:0] VOLT_COARSE_LIM = COARSE_W'(VOLT_COARSE_MAX);
   localparam logic [DLY_W-1:0]    MID_MUL         = DLY_W'(MID_WEIGHT);
   localparam logic [DLY_W-1:0]    COARSE_MUL      = DLY_W'(COARSE_WEIGHT);

   // Parameter sanity, checked when the design is elaborated.
   if (CUR_MID_MAX > 2 ** MID_W - 1) begin : g_bad_mid
      $error("middle limit does not fit its field");
   end
   if (CUR_COARSE_MAX > 2 ** COARSE_W - 1) begin : g_bad_coarse
      $error("coarse limit does not fit its field");
   end
   if (VOLT_MID_MAX > CUR_MID_MAX || VOLT_COARSE_MAX > CUR_COARSE_MAX) begin : g_bad_volt
      $error("voltage limits must not exceed current limits");
   end
   if (MID_WEIGHT < 2 ** FINE_W || COARSE_WEIGHT < MID_WEIGHT) begin : g_bad_weight
      $error("field weights must grow from fine to coarse");
   end

   logic [MID_W-1:0]    mid_lim, mid_sat;
   logic [COARSE_W-1:0] coarse_lim, coarse_sat;

   always_comb begin
      mid_lim    = (chan == DLY_VOLTAGE) ? VOLT_MID_LIM : CUR_MID_LIM;
      coarse_lim = (chan == DLY_VOLTAGE) ? VOLT_COARSE_LIM : CUR_COARSE_LIM;
      mid_sat    = (mid > mid_lim) ? mid_lim : mid;
      coarse_sat = (coarse > coarse_lim) ? coarse_lim : coarse;
      delay      = DLY_W'(fine)
                 + DLY_W'(mid_sat) * MID_MUL
                 + DLY_W'(coarse_sat) * COARSE_MUL;
   end

endmodule

// File: rtl/pad_sample_ring.sv
module pad_sample_ring #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 384,
   parameter int unsigned DLY_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic [DLY_W-1:0] delay,
   output logic [W-1:0]     dout
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ring needs at least two entries");
   end
   if (2 ** DLY_W < DEPTH) begin : g_bad_dlyw
      $error("delay width too narrow for ring depth");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   int unsigned      rd_calc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
      end else if (push) begin
         wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= din;
      end
   end

   // Entry written delay strobes ago; the modulo is done by hand since
   // the depth need not be a power of two.
   always_comb begin
      rd_calc = int'(wr_ptr) + DEPTH - int'(delay);
      if (rd_calc >= DEPTH) begin
         rd_calc = rd_calc - DEPTH;
      end
      rd_ptr = PTR_W'(rd_calc);
      dout   = (delay == '0) ? din : mem[rd_ptr];
   end

endmodule

// File: rtl/pad_fill_track.sv
module pad_fill_track
   import pad_pkg::*;
#(
   parameter int unsigned DLY_W   = 9,
   parameter int unsigned MAX_DLY = 383
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  dly_chan_e        chan,
   input  logic [DLY_W-1:0] delay,
   output logic             ready
);

   localparam logic [DLY_W-1:0] CNT_TOP = DLY_W'(MAX_DLY);

   logic [DLY_W-1:0] fill_cnt, fill_eff, prev_dly;
   dly_chan_e        prev_chan;
   logic             cfg_moved;

   always_comb begin
      cfg_moved = (delay != prev_dly) || (chan != prev_chan);
      fill_eff  = cfg_moved ? '0 : fill_cnt;
      ready     = (fill_eff >= delay);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_cnt  <= '0;
         prev_dly  <= '0;
         prev_chan <= DLY_CURRENT;
      end else begin
         prev_dly  <= delay;
         prev_chan <= chan;
         if (push) begin
            fill_cnt <= (fill_eff >= CNT_TOP) ? CNT_TOP : fill_eff + 1'b1;
         end else begin
            fill_cnt <= fill_eff;
         end
      end
   end

endmodule

// File: rtl/phase_align_delay.sv
module phase_align_delay
   import pad_pkg::*;
#(
   parameter int unsigned SAMPLE_W        = 16,
   parameter int unsigned FINE_W          = 5,
   parameter int unsigned MID_W           = 2,
   parameter int unsigned COARSE_W        = 2,
   parameter int unsigned MID_WEIGHT      = 32,
   parameter int unsigned COARSE_WEIGHT   = 128,
   parameter int unsigned CUR_MID_MAX     = 3,
   parameter int unsigned CUR_COARSE_MAX  = 2,
   parameter int unsigned VOLT_MID_MAX    = 1,
   parameter int unsigned VOLT_COARSE_MAX = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_stb,
   input  logic [SAMPLE_W-1:0] v_smp,
   input  logic [SAMPLE_W-1:0] i_smp,
   input  logic [FINE_W-1:0]   dly_fine,
   input  logic [MID_W-1:0]    dly_mid,
   input  logic [COARSE_W-1:0] dly_coarse,
   input  logic                dly_on_volt,
   output logic [SAMPLE_W-1:0] v_aligned,
   output logic [SAMPLE_W-1:0] i_aligned,
   output logic                aligned_vld
);

   localparam int unsigned MAX_DLY = pad_max_delay(FINE_W, MID_WEIGHT, CUR_MID_MAX,
                                                   COARSE_WEIGHT, CUR_COARSE_MAX);
   localparam int unsigned DLY_W   = $clog2(MAX_DLY + 1);
   localparam int unsigned DEPTH   = MAX_DLY + 1;
   localparam int unsigned N_CHAN  = 2;

   if (SAMPLE_W < 1) begin : g_bad_width
      $error("sample width must be positive");
   end

   dly_chan_e            chan;
   logic [DLY_W-1:0]     eff_delay;
   logic [SAMPLE_W-1:0]  ring_din, ring_dout;
   logic                 fill_ready;
   logic [SAMPLE_W-1:0]  chan_in  [N_CHAN];
   logic [SAMPLE_W-1:0]  chan_out [N_CHAN];
   logic                 vld_q;

   assign chan     = dly_chan_e'(dly_on_volt);
   assign chan_in[0] = v_smp;
   assign chan_in[1] = i_smp;
   assign ring_din = (chan == DLY_VOLTAGE) ? v_smp : i_smp;

   pad_delay_calc #(
      .FINE_W         (FINE_W),
      .MID_W          (MID_W),
      .COARSE_W       (COARSE_W),
      .MID_WEIGHT     (MID_WEIGHT),
      .COARSE_WEIGHT  (COARSE_WEIGHT),
      .CUR_MID_MAX    (CUR_MID_MAX),
      .CUR_COARSE_MAX (CUR_COARSE_MAX),
      .VOLT_MID_MAX   (VOLT_MID_MAX),
      .VOLT_COARSE_MAX(VOLT_COARSE_MAX),
      .DLY_W          (DLY_W)
   ) i_calc (
      .fine  (dly_fine),
      .mid   (dly_mid),
      .coarse(dly_coarse),
      .chan  (chan),
      .delay (eff_delay)
   );

   pad_sample_ring #(
      .W    (SAMPLE_W),
      .DEPTH(DEPTH),
      .DLY_W(DLY_W)
   ) i_ring (
      .clk  (clk),
      .rst_n(rst_n),
      .push (smp_stb),
      .din  (ring_din),
      .delay(eff_delay),
      .dout (ring_dout)
   );

   pad_fill_track #(
      .DLY_W  (DLY_W),
      .MAX_DLY(MAX_DLY)
   ) i_fill (
      .clk  (clk),
      .rst_n(rst_n),
      .push (smp_stb),
      .chan (chan),
      .delay(eff_delay),
      .ready(fill_ready)
   );

   // One output register per stream; index 0 is voltage, 1 is current.
   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      localparam dly_chan_e OWN_CHAN = (c == 0) ? DLY_VOLTAGE : DLY_CURRENT;
      logic [SAMPLE_W-1:0] out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '0;
         end else if (smp_stb) begin
            out_q <= (chan == OWN_CHAN) ? ring_dout : chan_in[c];
         end
      end

      assign chan_out[c] = out_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= smp_stb && fill_ready;
      end
   end

   assign v_aligned   = chan_out[0];
   assign i_aligned   = chan_out[1];
   assign aligned_vld = vld_q;

endmodule

// File: rtl/pad_align_chk.sv
module pad_align_chk #(
   parameter int unsigned SAMPLE_W        = 16,
   parameter int unsigned FINE_W          = 5,
   parameter int unsigned MID_W           = 2,
   parameter int unsigned COARSE_W        = 2,
   parameter int unsigned MID_WEIGHT      = 32,
   parameter int unsigned COARSE_WEIGHT   = 128,
   parameter int unsigned CUR_MID_MAX     = 3,
   parameter int unsigned CUR_COARSE_MAX  = 2,
   parameter int unsigned VOLT_MID_MAX    = 1,
   parameter int unsigned VOLT_COARSE_MAX = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                smp_stb,
   input logic [SAMPLE_W-1:0] v_smp,
   input logic [SAMPLE_W-1:0] i_smp,
   input logic [FINE_W-1:0]   dly_fine,
   input logic [MID_W-1:0]    dly_mid,
   input logic [COARSE_W-1:0] dly_coarse,
   input logic                dly_on_volt,
   input logic [SAMPLE_W-1:0] v_aligned,
   input logic [SAMPLE_W-1:0] i_aligned,
   input logic                aligned_vld
);

   int unsigned m_use, c_use, want_dly, prev_want;
   logic        prev_volt, cfg_new;

   always_comb begin
      m_use = dly_on_volt ? ((int'(dly_mid) > VOLT_MID_MAX) ? VOLT_MID_MAX : int'(dly_mid))
                          : ((int'(dly_mid) > CUR_MID_MAX) ? CUR_MID_MAX : int'(dly_mid));
      c_use = dly_on_volt ? ((int'(dly_coarse) > VOLT_COARSE_MAX) ? VOLT_COARSE_MAX : int'(dly_coarse))
                          : ((int'(dly_coarse) > CUR_COARSE_MAX) ? CUR_COARSE_MAX : int'(dly_coarse));
      want_dly = int'(dly_fine) + m_use * MID_WEIGHT + c_use * COARSE_WEIGHT;
      cfg_new  = (want_dly != prev_want) || (dly_on_volt != prev_volt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_want <= 0;
         prev_volt <= 1'b0;
      end else begin
         prev_want <= want_dly;
         prev_volt <= dly_on_volt;
      end
   end

   assert_vld_needs_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_vld |-> $past(smp_stb));

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> ($stable(v_aligned) && $stable(i_aligned) && !aligned_vld));

   assert_other_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      aligned_vld |-> ($past(dly_on_volt) ? (i_aligned == $past(i_smp))
                                          : (v_aligned == $past(v_smp))));

   assert_refill_after_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && cfg_new && want_dly != 0) |=> !aligned_vld);

endmodule

bind phase_align_delay pad_align_chk #(
   .SAMPLE_W       (SAMPLE_W),
   .FINE_W         (FINE_W),
   .MID_W          (MID_W),
   .COARSE_W       (COARSE_W),
   .MID_WEIGHT     (MID_WEIGHT),
   .COARSE_WEIGHT  (COARSE_WEIGHT),
   .CUR_MID_MAX    (CUR_MID_MAX),
   .CUR_COARSE_MAX (CUR_COARSE_MAX),
   .VOLT_MID_MAX   (VOLT_MID_MAX),
   .VOLT_COARSE_MAX(VOLT_COARSE_MAX)
) i_pad_align_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_stb    (smp_stb),
   .v_smp      (v_smp),
   .i_smp      (i_smp),
   .dly_fine   (dly_fine),
   .dly_mid    (dly_mid),
   .dly_coarse (dly_coarse),
   .dly_on_volt(dly_on_volt),
   .v_aligned  (v_aligned),
   .i_aligned  (i_aligned),
   .aligned_vld(aligned_vld)
);

// File: tb/test_phase_align_delay.sv
`timescale 1ns/1ps
module test_phase_align_delay;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [15:0] v_smp = '0;
   logic [15:0] i_smp = '0;
   logic [4:0]  dly_fine = '0;
   logic [1:0]  dly_mid = '0;
   logic [1:0]  dly_coarse = '0;
   logic        dly_on_volt = 1'b0;
   logic [15:0] v_aligned, i_aligned;
   logic        aligned_vld;

   always #4 clk = ~clk;

   phase_align_delay i_phase_align_delay (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .v_smp(v_smp), .i_smp(i_smp),
      .dly_fine(dly_fine), .dly_mid(dly_mid), .dly_coarse(dly_coarse),
      .dly_on_volt(dly_on_volt), .v_aligned(v_aligned), .i_aligned(i_aligned),
      .aligned_vld(aligned_vld)
   );

   typedef struct packed {
      logic       volt;
      logic [4:0] fine;
      logic [1:0] mid;
      logic [1:0] coarse;
      logic [1:0] gap;
      logic [8:0] dly;
      logic [3:0] req;
   } vec_t;

   // Expected delays worked out by hand from R2, R4, R5.
   localparam vec_t VEC [10] = '{
      '{1'b0, 5'd0,  2'd0, 2'd0, 2'd0, 9'd0,   4'd1},  // R1 zero delay
      '{1'b0, 5'd5,  2'd0, 2'd0, 2'd0, 9'd5,   4'd1},  // R1
      '{1'b0, 5'd31, 2'd0, 2'd0, 2'd1, 9'd31,  4'd9},  // R9 idle gaps
      '{1'b0, 5'd0,  2'd1, 2'd0, 2'd0, 9'd32,  4'd2},  // R2 middle weight
      '{1'b0, 5'd3,  2'd3, 2'd1, 2'd0, 9'd227, 4'd2},  // R2 mix
      '{1'b0, 5'd31, 2'd3, 2'd3, 2'd0, 9'd383, 4'd4},  // R4 coarse 3 -> 2
      '{1'b0, 5'd1,  2'd2, 2'd2, 2'd0, 9'd321, 4'd2},  // R2 coarse weight
      '{1'b1, 5'd7,  2'd0, 2'd0, 2'd0, 9'd7,   4'd3},  // R3 voltage delayed
      '{1'b1, 5'd31, 2'd3, 2'd2, 2'd2, 9'd63,  4'd5},  // R5 clamp, gaps
      '{1'b1, 5'd0,  2'd2, 2'd3, 2'd0, 9'd32,  4'd5}   // R5 coarse ignored
   };

   int total = 0;
   int bad = 0;
   int k = 0;
   bit finished = 1'b0;
   logic [15:0] cap_v, cap_i;
   logic        cap_vld;

   function automatic logic [15:0] vs(input int n);
      return 16'(n * 3 + 1);
   endfunction

   function automatic logic [15:0] is_(input int n);
      return 16'(n * 7 + 2);
   endfunction

   task automatic check(input bit ok, input int req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Drive one strobe at a falling edge and capture the result one edge later.
   task automatic strobe(input int gap);
      smp_stb = 1'b1;
      v_smp   = vs(k);
      i_smp   = is_(k);
      @(negedge clk);
      cap_v   = v_aligned;
      cap_i   = i_aligned;
      cap_vld = aligned_vld;
      smp_stb = 1'b0;
      k++;
      repeat (gap) @(negedge clk);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      check(aligned_vld == 1'b0, 6, "valid in reset", aligned_vld, 0);
      check(v_aligned == '0 && i_aligned == '0, 6, "data in reset", v_aligned, 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VEC[n]) begin
         dly_on_volt = VEC[n].volt;
         dly_fine    = VEC[n].fine;
         dly_mid     = VEC[n].mid;
         dly_coarse  = VEC[n].coarse;
         for (int j = 0; j <= int'(VEC[n].dly) + 2; j++) begin
            int kk;
            int d;
            kk = k;
            d  = int'(VEC[n].dly);
            strobe(int'(VEC[n].gap));
            // R8: first valid exactly at strobe D after the change
            check(cap_vld == (j >= d), int'(VEC[n].req), "valid position", cap_vld, j >= d);
            if (j >= d) begin
               if (VEC[n].volt) begin
                  check(cap_v == vs(kk - d), int'(VEC[n].req), "delayed voltage", cap_v, vs(kk - d));
                  check(cap_i == is_(kk), 3, "undelayed current", cap_i, is_(kk));
               end else begin
                  check(cap_i == is_(kk - d), int'(VEC[n].req), "delayed current", cap_i, is_(kk - d));
                  check(cap_v == vs(kk), 3, "undelayed voltage", cap_v, vs(kk));
               end
            end
         end
      end

      // R7: idle cycle after a strobe drops valid and holds data
      strobe(0);
      @(negedge clk);
      check(aligned_vld == 1'b0, 7, "valid after idle", aligned_vld, 0);
      check(v_aligned == cap_v && i_aligned == cap_i, 7, "hold on idle", v_aligned, cap_v);

      // R6 and R8: reset with a non-zero setting forces a refill of 5 strobes
      dly_on_volt = 1'b0;
      dly_fine = 5'd5;
      dly_mid = 2'd0;
      dly_coarse = 2'd0;
      rst_n = 1'b0;
      @(negedge clk);
      check(v_aligned == '0 && aligned_vld == 1'b0, 6, "mid-run reset", v_aligned, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int j = 0; j < 6; j++) begin
         strobe(0);
         check(cap_vld == (j >= 5), 8, "refill after reset", cap_vld, j >= 5);
      end
      check(cap_i == is_(k - 1 - 5), 1, "delay after reset", cap_i, is_(k - 1 - 5));

      finished = 1'b1;
      summary();
   end

endmodule